// File: doc/BRIEF.md
# Warp Memory Request Coalescer

The coalescer receives one memory request for a whole warp of parallel lanes. Each lane supplies a byte address and an active bit, and the request as a whole carries a load/store flag and a flag that requests line-cached loads. The block sorts the active lanes by the 128-byte aligned line that each one touches. It then presents one memory transaction per touched line, one at a time, on a valid/ready output. Each transaction gives a base address, a size code and the mask of lanes it serves.

Line-cached loads always fetch a whole line. Uncached loads and every store use 32-byte segment granularity: a transaction covers one segment, an aligned 64-byte half line, or the full line. The block takes the smallest of these shapes that covers every segment the lanes touch. Scattered or misaligned lanes therefore cost extra transactions, issued back to back in ascending address order. A request is accepted only when the previous request has finished, and a single-cycle done pulse marks the end of each request.

Top module: `warp_coalescer`

## Requirements
- R1: `req_ready` is high only when no request is in progress. It goes low in the cycle after a request is accepted. `txn_valid` and `req_ready` are never high together.
- R2: For a cached load (`req_l1`=1, `req_store`=0) the block issues one transaction for each 128-byte line touched. Each has size code 2 (128 bytes) and a base on the 128-byte line boundary.
- R3: For uncached loads and for stores, the block still issues one transaction per touched line. If only one 32-byte segment of the line is touched, the size code is 0 (32 bytes) and the base is that segment's address.
- R4: In the uncached or store case, if the touched segments all lie within one 64-byte aligned half of the line and there is more than one of them, the size code is 1 (64 bytes) and the base is that half's address.
- R5: In the uncached or store case, if the touched segments lie in both halves of the line, the transaction is widened to the whole line, with size code 2 and the line base. This covers three segments, and two segments that are not in the same half.
- R6: A store is never treated as cached. A store with `req_l1`=1 produces the same transactions as with `req_l1`=0.
- R7: Transactions are issued in strictly ascending base address order, whatever the lane order. A 128-byte run of words that does not start on a line boundary becomes two transactions.
- R8: Each `txn_mask` marks exactly the active lanes whose address falls in that transaction's line. Bit i of the mask is lane i. Every active lane is served exactly once, and inactive lanes never appear.
- R9: While `txn_valid` is high and `txn_ready` is low, the base, size and mask stay unchanged.
- R10: `done` is high for one cycle, in the cycle in which the final transaction of a request is accepted (`txn_valid` and `txn_ready` both high).
- R11: A request with no active lanes issues no transaction. `done` is high, with `txn_valid` low, in the cycle after acceptance.
- R12: Bits [1:0] of every lane address have no effect on the transactions issued.
- R13: After reset, `req_ready` is high and `txn_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request may be taken |
| req_store | input | 1 | 1 = store, 0 = load |
| req_l1 | input | 1 | 1 = line-cached load requested |
| req_active | input | LANES | Active bit per lane |
| req_addr | input | LANES*AW | Byte address per lane, lane i in bits [i*AW +: AW] |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Transaction accepted this cycle |
| txn_base | output | AW | Transaction base byte address |
| txn_size | output | 2 | 0 = 32 B, 1 = 64 B, 2 = 128 B |
| txn_mask | output | LANES | Lanes served by this transaction |
| done | output | 1 | Request finished |

## Verification
The last transaction handshake and the done pulse fall in the same cycle, and both depend on `txn_ready` in that cycle. The bench drives `txn_ready` at random, so the final transaction of a request is often stalled before it is taken. In every sampled cycle the bench expects `done` to be high exactly when the presented transaction is the last one computed for the request and `txn_ready` is high. A request is judged complete only if the pulse arrives with exactly the expected number of accepted transactions.

// File: rtl/wc_pkg.sv
package wc_pkg;

    typedef enum logic [1:0] {
        SZ_SEG  = 2'd0,
        SZ_HALF = 2'd1,
        SZ_LINE = 2'd2
    } txn_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_EMPTY = 2'd2
    } wc_state_e;

endpackage

// File: rtl/wc_group_pick.sv
module wc_group_pick #(
    parameter int LANES      = 32,
    parameter int AW         = 32,
    parameter int LINE_BYTES = 128,
    parameter int SEG_BYTES  = 32,
    localparam int LOFF      = $clog2(LINE_BYTES),
    localparam int SOFF      = $clog2(SEG_BYTES),
    localparam int LW        = AW - LOFF,
    localparam int SW        = LOFF - SOFF,
    localparam int SEGS      = LINE_BYTES / SEG_BYTES
) (
    input  logic [LANES*AW-1:0] addr_flat,
    input  logic [LANES-1:0]    pend,
    output logic [LW-1:0]       min_line,
    output logic [LANES-1:0]    grp,
    output logic [SEGS-1:0]     segs
);

    logic [LW-1:0] lane_line [LANES];
    logic [SW-1:0] lane_seg  [LANES];
    logic          unused_low;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_line[i] = addr_flat[i*AW+LOFF +: LW];
        assign lane_seg[i]  = addr_flat[i*AW+SOFF +: SW];
    end

    // Bits below the segment offset never shape a transaction.
    always_comb begin
        unused_low = 1'b0;
        for (int i = 0; i < LANES; i++)
            unused_low = unused_low ^ (^addr_flat[i*AW +: SOFF]);
    end

    // Lowest line among the lanes still waiting.
    always_comb begin
        min_line = '1;
        for (int i = 0; i < LANES; i++)
            if (pend[i] && (lane_line[i] < min_line))
                min_line = lane_line[i];
    end

    // Lanes in that line, and the segments they touch.
    always_comb begin
        grp  = '0;
        segs = '0;
        for (int i = 0; i < LANES; i++) begin
            grp[i] = pend[i] && (lane_line[i] == min_line);
            if (grp[i])
                segs[lane_seg[i]] = 1'b1;
        end
    end

endmodule

// File: rtl/wc_txn_shape.sv
module wc_txn_shape
    import wc_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 128,
    parameter int SEG_BYTES  = 32,
    localparam int LOFF      = $clog2(LINE_BYTES),
    localparam int SOFF      = $clog2(SEG_BYTES),
    localparam int LW        = AW - LOFF,
    localparam int SEGS      = LINE_BYTES / SEG_BYTES,
    localparam int HALF      = SEGS / 2
) (
    input  logic [LW-1:0]   line,
    input  logic [SEGS-1:0] segs,
    input  logic            cached,
    output logic [AW-1:0]   base,
    output txn_size_e       size
);

    logic [AW-1:0] line_base;
    logic [AW-1:0] seg_base;
    logic          lo_touched;
    logic          hi_touched;

    assign line_base  = {line, {LOFF{1'b0}}};
    assign lo_touched = |segs[HALF-1:0];
    assign hi_touched = |segs[SEGS-1:HALF];

    always_comb begin
        seg_base = line_base;
        for (int s = 0; s < SEGS; s++)
            if (segs[s])
                seg_base = line_base | (AW'(s) << SOFF);
    end

    always_comb begin
        base = line_base;
        size = SZ_LINE;
        if (!cached) begin
            if ($countones(segs) == 1) begin
                base = seg_base;
                size = SZ_SEG;
            end else if (!hi_touched) begin
                base = line_base;
                size = SZ_HALF;
            end else if (!lo_touched) begin
                base = line_base | AW'(LINE_BYTES / 2);
                size = SZ_HALF;
            end
        end
    end

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import wc_pkg::*;
#(
    parameter int LANES      = 32,
    parameter int AW         = 32,
    parameter int LINE_BYTES = 128,
    parameter int SEG_BYTES  = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_store,
    input  logic                req_l1,
    input  logic [LANES-1:0]    req_active,
    input  logic [LANES*AW-1:0] req_addr,
    output logic                txn_valid,
    input  logic                txn_ready,
    output logic [AW-1:0]       txn_base,
    output logic [1:0]          txn_size,
    output logic [LANES-1:0]    txn_mask,
    output logic                done
);

    localparam int LOFF = $clog2(LINE_BYTES);
    localparam int LW   = AW - LOFF;
    localparam int SEGS = LINE_BYTES / SEG_BYTES;

    wc_state_e           state_q;
    logic [LANES*AW-1:0] addr_q;
    logic [LANES-1:0]    pend_q;
    logic                cached_q;

    logic [LW-1:0]       cur_line;
    logic [LANES-1:0]    cur_grp;
    logic [SEGS-1:0]     cur_segs;
    txn_size_e           cur_size;
    logic                last_txn;

    wc_group_pick #(
        .LANES(LANES), .AW(AW), .LINE_BYTES(LINE_BYTES), .SEG_BYTES(SEG_BYTES)
    ) u_pick (
        .addr_flat(addr_q),
        .pend     (pend_q),
        .min_line (cur_line),
        .grp      (cur_grp),
        .segs     (cur_segs)
    );

    wc_txn_shape #(
        .AW(AW), .LINE_BYTES(LINE_BYTES), .SEG_BYTES(SEG_BYTES)
    ) u_shape (
        .line  (cur_line),
        .segs  (cur_segs),
        .cached(cached_q),
        .base  (txn_base),
        .size  (cur_size)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign txn_valid = (state_q == ST_ISSUE);
    assign txn_size  = cur_size;
    assign txn_mask  = cur_grp;
    assign last_txn  = ((pend_q & ~cur_grp) == '0);
    assign done      = (state_q == ST_EMPTY) || (txn_valid && txn_ready && last_txn);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            addr_q   <= '0;
            pend_q   <= '0;
            cached_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q   <= req_addr;
                        pend_q   <= req_active;
                        cached_q <= req_l1 && !req_store;
                        state_q  <= (|req_active) ? ST_ISSUE : ST_EMPTY;
                    end
                end
                ST_ISSUE: begin
                    if (txn_ready) begin
                        pend_q <= pend_q & ~cur_grp;
                        if (last_txn)
                            state_q <= ST_IDLE;
                    end
                end
                ST_EMPTY: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wc_checker.sv
module wc_checker #(
    parameter int LANES      = 32,
    parameter int AW         = 32,
    parameter int LINE_BYTES = 128,
    parameter int SEG_BYTES  = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [LANES-1:0] req_active,
    input logic             txn_valid,
    input logic             txn_ready,
    input logic [AW-1:0]    txn_base,
    input logic [1:0]       txn_size,
    input logic [LANES-1:0] txn_mask,
    input logic             done
);

    localparam int LOFF = $clog2(LINE_BYTES);
    localparam int SOFF = $clog2(SEG_BYTES);

    logic [LANES-1:0] rem_q;
    logic [AW-1:0]    prev_base;
    logic             have_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q     <= '0;
            prev_base <= '0;
            have_prev <= 1'b0;
        end else if (req_valid && req_ready) begin
            rem_q     <= req_active;
            have_prev <= 1'b0;
        end else if (txn_valid && txn_ready) begin
            rem_q     <= rem_q & ~txn_mask;
            prev_base <= txn_base;
            have_prev <= !done;
        end
    end

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> !req_ready); // R1
    AST_LINE_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && txn_size == 2'd2) |-> (txn_base[LOFF-1:0] == '0)); // R2
    AST_SEG_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && txn_size == 2'd0) |-> (txn_base[SOFF-1:0] == '0)); // R3
    AST_HALF_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && txn_size == 2'd1) |-> (txn_base[LOFF-2:0] == '0)); // R4
    AST_SIZE_CODE: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> (txn_size != 2'd3)); // R5
    AST_ASCENDING: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && have_prev) |-> (txn_base > prev_base)); // R7
    AST_MASK_FRESH: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> (txn_mask != '0 && (txn_mask & ~rem_q) == '0)); // R8
    AST_ALL_SERVED: assert property (@(posedge clk) disable iff (rst)
        (done && txn_valid) |-> ((rem_q & ~txn_mask) == '0)); // R8
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base)
            && $stable(txn_size) && $stable(txn_mask))); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_DONE_WITH_LAST: assert property (@(posedge clk) disable iff (rst)
        (done && txn_valid) |-> txn_ready); // R10
    AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_active == '0) |=> (done && !txn_valid)); // R11

endmodule

bind warp_coalescer wc_checker #(
    .LANES(LANES), .AW(AW), .LINE_BYTES(LINE_BYTES), .SEG_BYTES(SEG_BYTES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_active(req_active),
    .txn_valid (txn_valid),
    .txn_ready (txn_ready),
    .txn_base  (txn_base),
    .txn_size  (txn_size),
    .txn_mask  (txn_mask),
    .done      (done)
);

// File: tb/warp_coalescer_test.sv
module warp_coalescer_test;

    localparam int LANES = 32;
    localparam int AW    = 32;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                req_valid = 1'b0;
    logic                req_ready;
    logic                req_store = 1'b0;
    logic                req_l1 = 1'b0;
    logic [LANES-1:0]    req_active = '0;
    logic [LANES*AW-1:0] req_addr = '0;
    logic                txn_valid;
    logic                txn_ready = 1'b0;
    logic [AW-1:0]       txn_base;
    logic [1:0]          txn_size;
    logic [LANES-1:0]    txn_mask;
    logic                done;

    warp_coalescer uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_store(req_store), .req_l1(req_l1), .req_active(req_active),
        .req_addr(req_addr), .txn_valid(txn_valid), .txn_ready(txn_ready),
        .txn_base(txn_base), .txn_size(txn_size), .txn_mask(txn_mask), .done(done)
    );

    always #10 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int ready_pct = 70;

    logic [31:0] la [LANES];
    logic [31:0] eb [LANES];
    logic [1:0]  es [LANES];
    logic [31:0] em [LANES];
    int          en;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Expected transactions, computed from the requirements.
    task automatic model(input logic [31:0] act, input bit st, input bit l1);
        logic [31:0] pend;
        logic [24:0] mn;
        logic [31:0] grp;
        logic [3:0]  sg;
        pend = act;
        en = 0;
        while (pend != 0) begin
            mn = '1;
            for (int i = 0; i < LANES; i++)
                if (pend[i] && la[i][31:7] < mn) mn = la[i][31:7];
            grp = 0;
            sg = 0;
            for (int i = 0; i < LANES; i++)
                if (pend[i] && la[i][31:7] == mn) begin
                    grp[i] = 1'b1;
                    sg[la[i][6:5]] = 1'b1;
                end
            pend = pend & ~grp;
            em[en] = grp;
            eb[en] = {mn, 7'd0};
            es[en] = 2'd2;
            if (!(l1 && !st)) begin
                if ($countones(sg) == 1) begin
                    es[en] = 2'd0;
                    for (int s = 0; s < 4; s++)
                        if (sg[s]) eb[en] = {mn, 7'd0} + 32'(s * 32);
                end else if (sg[3:2] == 0) begin
                    es[en] = 2'd1;
                end else if (sg[1:0] == 0) begin
                    es[en] = 2'd1;
                    eb[en] = {mn, 7'd0} + 32'd64;
                end
            end
            en++;
        end
    endtask

    task automatic run(input logic [31:0] act, input bit st, input bit l1, input string req);
        int k;
        int guard;
        model(act, st, l1);
        @(negedge clk);
        check(req_ready === 1'b1, "R1", "ready before request", 64'(req_ready), 64'd1);
        for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = la[i];
        req_active = act;
        req_store  = st;
        req_l1     = l1;
        req_valid  = 1'b1;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        check(req_ready === 1'b0, "R1", "ready after accept", 64'(req_ready), 64'd0);
        if (en == 0) begin
            @(negedge clk);
            check(done === 1'b1 && txn_valid === 1'b0, "R11", "empty request done",
                  64'({done, txn_valid}), 64'b10);
            @(negedge clk);
            check(done === 1'b0 && req_ready === 1'b1, "R11", "empty request end",
                  64'({done, req_ready}), 64'b01);
        end else begin
            k = 0;
            guard = 0;
            while (k < en && guard < 3000) begin
                @(negedge clk);
                txn_ready = (($urandom % 100) < ready_pct);
                #1;
                guard++;
                if (txn_valid !== 1'b1) begin
                    check(1'b0, "R8", "missing transaction", 64'(txn_valid), 64'd1);
                    break;
                end
                check(txn_base === eb[k], req, "txn base", 64'(txn_base), 64'(eb[k]));
                check(txn_size === es[k], req, "txn size", 64'(txn_size), 64'(es[k]));
                check(txn_mask === em[k], "R8", "txn mask", 64'(txn_mask), 64'(em[k]));
                check(req_ready === 1'b0, "R1", "ready while busy", 64'(req_ready), 64'd0);
                check(done === (txn_ready && k == en - 1), "R10", "done timing",
                      64'(done), 64'(txn_ready && k == en - 1));
                if (txn_ready) k++;
            end
            @(negedge clk);
            txn_ready = 1'b0;
            #1;
            check(txn_valid === 1'b0 && req_ready === 1'b1, "R8", "no extra transaction",
                  64'({txn_valid, req_ready}), 64'b01);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(req_ready === 1'b1 && txn_valid === 1'b0 && done === 1'b0, "R13", "reset state",
              64'({req_ready, txn_valid, done}), 64'b100);

        // R3/R5: fully coalesced aligned load, uncached: one full-line transaction
        for (int i = 0; i < LANES; i++) la[i] = 32'h1000 + 32'(4 * i);
        run('1, 1'b0, 1'b0, "R5");
        // R2: same, line cached
        run('1, 1'b0, 1'b1, "R2");
        // R7: shifted by one word, two transactions
        for (int i = 0; i < LANES; i++) la[i] = 32'h1004 + 32'(4 * i);
        run('1, 1'b0, 1'b0, "R7");
        run('1, 1'b0, 1'b1, "R7");
        // R7/R5: lanes in descending address order, segments 0 and 2 per line
        for (int i = 0; i < LANES; i++) la[i] = 32'h2000 + 32'((31 - i) * 64);
        run('1, 1'b0, 1'b0, "R7");
        // R4: upper half and lower half only
        for (int i = 0; i < LANES; i++) la[i] = 32'h3040 + 32'((i % 16) * 4);
        run('1, 1'b0, 1'b0, "R4");
        for (int i = 0; i < LANES; i++) la[i] = 32'h3000 + 32'((i % 16) * 4);
        run('1, 1'b0, 1'b0, "R4");
        // R6: stores ignore the cached flag
        for (int i = 0; i < LANES; i++) la[i] = 32'h3040 + 32'((i % 16) * 4);
        run('1, 1'b1, 1'b1, "R6");
        for (int i = 0; i < LANES; i++) la[i] = 32'h3020 + 32'((i % 8) * 4);
        run('1, 1'b1, 1'b1, "R6");
        // R3: a single active lane
        for (int i = 0; i < LANES; i++) la[i] = 32'hFFFF_0000;
        la[7] = 32'h4A6C;
        run(32'h0000_0080, 1'b0, 1'b0, "R3");
        // R3: every lane in its own line
        for (int i = 0; i < LANES; i++) la[i] = 32'(i * 32'h1000) + 32'((i % 4) * 32);
        run('1, 1'b0, 1'b0, "R3");
        // R11: no active lanes
        run('0, 1'b0, 1'b0, "R11");
        run('0, 1'b1, 1'b1, "R11");
        // R12: low address bits are noise
        for (int i = 0; i < LANES; i++) la[i] = 32'h5000 + 32'(4 * i) + 32'(i % 4);
        run(32'h0000_00FF, 1'b0, 1'b0, "R12");
        for (int i = 0; i < LANES; i++) la[i] = 32'h5000 + 32'(4 * i) + 32'd3;
        run('1, 1'b1, 1'b0, "R12");
        // R9: heavy back-pressure
        ready_pct = 20;
        for (int i = 0; i < LANES; i++) la[i] = 32'h6000 + 32'(i * 96);
        run('1, 1'b0, 1'b0, "R9");
        ready_pct = 70;
        // Sweep: random lanes in a small window, random modes and masks
        for (int t = 0; t < 400; t++) begin
            logic [31:0] act;
            for (int i = 0; i < LANES; i++)
                la[i] = (t % 3 == 0) ? ($urandom & 32'h3FF) : ($urandom & 32'hFFFF);
            act = (t % 5 == 0) ? '1 : $urandom;
            ready_pct = 30 + int'($urandom % 71);
            run(act, 1'($urandom), 1'($urandom), "R8");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule